// File: doc/BRIEF.md
# Clock Group Output Mode Decoder

This block turns a three-bit select code into an operating mode for seven clock output groups: CPU, half-rate CPU, fixed 66 MHz, PCI, 48 MHz, reference and APIC. For each group it drives a tri-state enable and the clock value that the pad should carry. Every group can be switched to high impedance for board test. The 48 MHz group can be parked in high impedance while the rest run. There is also a test mode in which every group is derived from the block's own input clock.

In normal operation the frequency sources come from outside the block and are only selected and gated here. The upper select bit picks the 133 MHz or 100 MHz CPU source, together with the matching 66 MHz or 50 MHz half-rate source. In test mode one binary counter clocked by the test clock supplies every divided output, each at its own fixed ratio. The counter restarts from zero each time test mode is entered, so the divided edges line up with one another.

The select code is resynchronized into the test clock domain before it is decoded. A group that is disabled drives its clock output low as well as dropping its enable.

Top module: `clkmode_decoder`

## Requirements
- R1: The select input passes through two flip-flops clocked by `tclk`. A new code changes `grp_oe` and `grp_clk` after the second rising edge of `tclk` following the change, and not after the first.
- R2: Code 000 drives all seven `grp_oe` bits low and all `grp_clk` bits low. Group bit order for both vectors is 0 CPU, 1 half-rate CPU, 2 fixed 66, 3 PCI, 4 48 MHz, 5 reference, 6 APIC.
- R3: Codes 001 and 101 behave exactly as code 000.
- R4: Codes 010 and 110 enable every group except the 48 MHz group. Its enable (bit 4) is low and its clock output is low, while the other groups pass their normal sources.
- R5: Codes 011 and 111 enable all seven groups and pass every normal source, including `src_usb`.
- R6: In the normal codes, select bit 2 high routes `src_cpu[1]` to the CPU group and `src_half[1]` to the half-rate group. Select bit 2 low routes `src_cpu[0]` and `src_half[0]`.
- R7: Code 100 is test mode. All enables are high. The output periods in `tclk` cycles are: CPU 2, half-rate 4, fixed 66 4, PCI 8, 48 MHz 2, APIC 16. The reference group carries `tclk` itself.
- R8: Each time test mode takes effect, the divider starts from zero. In the first `tclk` cycle of test mode, all divided outputs are low. Each output then follows bit k of a count that rises by one per `tclk` cycle, where k is 0 for period 2, 1 for period 4, 2 for period 8 and 3 for period 16.
- R9: In test mode, the PCI output changes only on an edge where the CPU output falls.
- R10: While `rst_n` is low, all enables and all clock outputs other than the reference are low, and the resynchronized code reads 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tclk | input | 1 | Block clock; test clock in test mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Mode select; bit 2 is CPU speed (1 = 133 MHz) |
| src_cpu | input | 2 | CPU sources: [0] 100 MHz, [1] 133 MHz |
| src_half | input | 2 | Half-rate sources: [0] 50 MHz, [1] 66 MHz |
| src_f66 | input | 1 | Fixed 66 MHz source |
| src_pci | input | 1 | PCI source |
| src_usb | input | 1 | 48 MHz source |
| src_ref | input | 1 | Reference source |
| src_apic | input | 1 | APIC source |
| grp_oe | output | 7 | Per-group tri-state enables |
| grp_clk | output | 7 | Per-group clock values |

## Verification
All eight select codes are applied. Distinct static levels on the sources show which source reaches each group, so a wrong pass-through or a wrong gate shows up as a wrong bit. The CPU and half-rate source levels are set opposite and then swapped between the two speed codes, which separates a correct speed select from one that is stuck or inverted. In test mode, each divided output is compared cycle by cycle against the count bit that its period implies, starting at zero. Test mode is then left and entered again, which separates a counter that restarts from one that resumes. One code change is sampled after a single edge and again after two edges, which pins down the synchronizer depth.

// File: rtl/clkmode_decoder.sv
module clkmode_decoder #(
  parameter int SEL_W = 3,
  parameter int DIV_W = 4
) (
  input  logic             tclk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       src_cpu,
  input  logic [1:0]       src_half,
  input  logic             src_f66,
  input  logic             src_pci,
  input  logic             src_usb,
  input  logic             src_ref,
  input  logic             src_apic,
  output logic [6:0]       grp_oe,
  output logic [6:0]       grp_clk
);
  localparam logic [SEL_W-1:0] TEST_CODE = SEL_W'(3'b100);

  logic [SEL_W-1:0] sel_meta, sel_q;
  logic [DIV_W-1:0] div_cnt;

  always_ff @(posedge tclk or negedge rst_n)
    if (!rst_n) begin
      sel_meta <= '0;
      sel_q    <= '0;
    end else begin
      sel_meta <= sel;
      sel_q    <= sel_meta;
    end

  wire test_m = (sel_q == TEST_CODE);
  wire run_m  = sel_q[1];
  wire usb_on = test_m | (run_m & sel_q[0]);
  wire any_on = test_m | run_m;

  always_ff @(posedge tclk or negedge rst_n)
    if (!rst_n)       div_cnt <= '0;
    else if (!test_m) div_cnt <= '0;
    else              div_cnt <= div_cnt + 1'b1;

  wire       cpu_n  = src_cpu[sel_q[2]];
  wire       half_n = src_half[sel_q[2]];
  wire [6:0] norm_v = {src_apic, src_ref, src_usb, src_pci, src_f66, half_n, cpu_n};
  wire [6:0] test_v = {div_cnt[3], tclk, div_cnt[0], div_cnt[2], div_cnt[1], div_cnt[1], div_cnt[0]};

  assign grp_oe  = {any_on, any_on, usb_on, any_on, any_on, any_on, any_on};
  assign grp_clk = (test_m ? test_v : norm_v) & grp_oe;

  logic [1:0] warm;
  always_ff @(posedge tclk or negedge rst_n)
    if (!rst_n)           warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;

  assert_hiz_code_R2: assert property (@(posedge tclk) disable iff (!rst_n)
    (warm == 2'd3 && $past(sel, 2) == 3'b000) |-> (grp_oe == 7'd0 && grp_clk == 7'd0));

  assert_reserved_hiz_R3: assert property (@(posedge tclk) disable iff (!rst_n)
    (warm == 2'd3 && ($past(sel, 2) == 3'b001 || $past(sel, 2) == 3'b101)) |-> (grp_oe == 7'd0));

  assert_usb_parked_R4: assert property (@(posedge tclk) disable iff (!rst_n)
    (warm == 2'd3 && $past(sel, 2) inside {3'b010, 3'b110}) |-> (grp_oe == 7'b1101111 && !grp_clk[4]));

  assert_cpu_toggle_R7: assert property (@(posedge tclk) disable iff (!rst_n)
    (test_m && $past(test_m)) |-> (grp_clk[0] != $past(grp_clk[0])));

  assert_entry_zero_R8: assert property (@(posedge tclk) disable iff (!rst_n)
    $rose(test_m) |-> ((grp_clk & 7'b1011111) == 7'd0));

  assert_pci_aligned_R9: assert property (@(posedge tclk) disable iff (!rst_n)
    (test_m && $past(test_m) && grp_clk[3] != $past(grp_clk[3])) |-> ($past(grp_clk[0]) && !grp_clk[0]));
endmodule

// File: tb/clkmode_decoder_test.sv
module clkmode_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic       tclk = 0;
  logic       rst_n = 0;
  logic [2:0] sel = 3'b000;
  logic [1:0] src_cpu = 2'b00, src_half = 2'b00;
  logic       src_f66 = 0, src_pci = 0, src_usb = 0, src_ref = 0, src_apic = 0;
  logic [6:0] grp_oe, grp_clk;
  int n_chk = 0, n_bad = 0;

  clkmode_decoder uut (
    .tclk(tclk), .rst_n(rst_n), .sel(sel), .src_cpu(src_cpu), .src_half(src_half),
    .src_f66(src_f66), .src_pci(src_pci), .src_usb(src_usb), .src_ref(src_ref),
    .src_apic(src_apic), .grp_oe(grp_oe), .grp_clk(grp_clk)
  );

  always #(CLK_PERIOD/2) tclk = ~tclk;

  task automatic chk(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge tclk);
    @(negedge tclk);
  endtask

  task automatic set_src(input logic [1:0] c, input logic [1:0] h, input logic [4:0] rest);
    src_cpu = c; src_half = h;
    {src_apic, src_ref, src_usb, src_pci, src_f66} = rest;
  endtask

  function automatic logic [6:0] norm_exp(input logic [2:0] code);
    logic [6:0] v;
    v = {src_apic, src_ref, src_usb, src_pci, src_f66, src_half[code[2]], src_cpu[code[2]]};
    if (code[1:0] == 2'b10) v[4] = 1'b0;
    return v;
  endfunction

  task automatic t_reset;
    chk(grp_oe == 7'd0, "R10 reset enables", grp_oe, 7'd0);
    chk((grp_clk & 7'b1011111) == 7'd0, "R10 reset clocks", grp_clk, 7'd0);
  endtask

  task automatic t_hiz_codes;
    set_src(2'b11, 2'b11, 5'b11111);
    sel = 3'b000; edges(2);
    chk(grp_oe == 7'd0, "R2 code000 oe", grp_oe, 7'd0);
    chk(grp_clk == 7'd0, "R2 code000 clk", grp_clk, 7'd0);
    sel = 3'b001; edges(2);
    chk(grp_oe == 7'd0 && grp_clk == 7'd0, "R3 code001", grp_oe | grp_clk, 7'd0);
    sel = 3'b101; edges(2);
    chk(grp_oe == 7'd0 && grp_clk == 7'd0, "R3 code101", grp_oe | grp_clk, 7'd0);
  endtask

  task automatic t_sync;
    sel = 3'b000; edges(2);
    sel = 3'b011; edges(1);
    chk(grp_oe == 7'd0, "R1 one edge no change", grp_oe, 7'd0);
    edges(1);
    chk(grp_oe == 7'h7f, "R1 second edge applied", grp_oe, 7'h7f);
  endtask

  task automatic t_normal;
    set_src(2'b01, 2'b10, 5'b10110);
    foreach (sel[i]) begin end
    sel = 3'b010; edges(2);
    chk(grp_oe == 7'b1101111, "R4 code010 oe", grp_oe, 7'b1101111);
    chk(grp_clk == norm_exp(3'b010), "R4 code010 clk", grp_clk, norm_exp(3'b010));
    sel = 3'b110; edges(2);
    chk(grp_oe == 7'b1101111, "R4 code110 oe", grp_oe, 7'b1101111);
    chk(grp_clk == norm_exp(3'b110), "R4 code110 clk", grp_clk, norm_exp(3'b110));
    sel = 3'b011; edges(2);
    chk(grp_oe == 7'h7f, "R5 code011 oe", grp_oe, 7'h7f);
    chk(grp_clk == norm_exp(3'b011), "R5 code011 clk", grp_clk, norm_exp(3'b011));
    sel = 3'b111; edges(2);
    chk(grp_oe == 7'h7f, "R5 code111 oe", grp_oe, 7'h7f);
    chk(grp_clk == norm_exp(3'b111), "R5 code111 clk", grp_clk, norm_exp(3'b111));
  endtask

  task automatic t_speed;
    set_src(2'b10, 2'b10, 5'b00000);
    sel = 3'b111; edges(2);
    chk(grp_clk[1:0] == 2'b11, "R6 fast picks [1]", grp_clk, 7'b0000011);
    sel = 3'b011; edges(2);
    chk(grp_clk[1:0] == 2'b00, "R6 slow picks [0]", grp_clk, 7'b0000000);
    set_src(2'b01, 2'b01, 5'b00000); edges(1);
    chk(grp_clk[1:0] == 2'b11, "R6 slow swapped", grp_clk, 7'b0000011);
    sel = 3'b111; edges(2);
    chk(grp_clk[1:0] == 2'b00, "R6 fast swapped", grp_clk, 7'b0000000);
  endtask

  task automatic t_test_mode(input string tag);
    logic [6:0] e;
    int bad = 0;
    logic [6:0] first_bad_a = 0, first_bad_e = 0;
    set_src(2'b11, 2'b11, 5'b11111);
    sel = 3'b100; edges(2);
    chk(grp_oe == 7'h7f, {tag, " R7 test oe"}, grp_oe, 7'h7f);
    for (int j = 0; j < 48; j++) begin
      e = {j[3], 1'b0, j[0], j[2], j[1], j[1], j[0]};
      if (grp_clk != e && bad == 0) begin first_bad_a = grp_clk; first_bad_e = e; end
      if (grp_clk != e) bad++;
      if (j == 0) chk(grp_clk == 7'd0, {tag, " R8 entry zero"}, grp_clk, 7'd0);
      @(posedge tclk); #1;
      if (j == 5) chk(grp_clk[5] == 1'b1, {tag, " R7 ref high"}, grp_clk, 7'b0100000);
      @(negedge tclk);
    end
    chk(bad == 0, {tag, " R7 R8 R9 divided periods"}, first_bad_a, first_bad_e);
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 1);
    t_reset;
    @(negedge tclk); rst_n = 1;
    t_hiz_codes;
    t_sync;
    t_normal;
    t_speed;
    t_test_mode("first");
    sel = 3'b011; edges(5);
    t_test_mode("reentry");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule